// File: doc/BRIEF.md
# Multi-Input Conversion Sequencer

This block decides which differential input pair a sigma-delta converter samples. One trigger starts a run. If the scan mask has bits set, the run visits every flagged input, from the lowest index to the highest. If the mask is empty, the run converts only the input named by the fixed selection field.

For each step the block drives `in_sel` and pulses `sel_stb` so that the downstream filter can flush. It then waits for the converter's result-done strobe. It captures that result together with the number of the input that produced it. `busy` is high from the start of a run to its end.

A run is triggered by a one-cycle software start. In free-run mode the block instead starts by itself whenever it is idle, and it wraps straight back to the first input after the last one. The mask and the fixed selection are sampled when a run starts, and again at each free-run wrap.

Top module: `conv_seq`

## Requirements
- R1: During and after synchronous reset, `busy`, `sel_stb` and `res_valid` are 0 and `in_sel` is 0.
- R2: When idle, a `sw_start` sampled high makes `busy` 1, pulses `sel_stb` for one cycle and drives `in_sel` to the lowest set bit of `seq_mask`, all in the cycle after the start.
- R3: Each accepted `conv_done` advances `in_sel` to the next higher set mask bit, with a one-cycle `sel_stb`, in the cycle after the strobe.
- R4: With an all-zero `seq_mask` at start, exactly one conversion is made, on input `mux_sel` (valid values 0 to NUM_IN-1).
- R5: With `free_run` low, `busy` falls in the cycle after the `conv_done` of the last input of the run.
- R6: In the cycle after an accepted `conv_done`, `res_valid` is 1 for one cycle, `res_data` equals the `conv_data` sampled with the strobe, and `res_tag` equals the `in_sel` value that was current at the strobe.
- R7: A `sw_start` while `busy` is 1 has no effect on `in_sel`, `sel_stb` or the order of the run.
- R8: A `conv_done` while idle produces no result and does not start a run.
- R9: With `free_run` high, an idle block starts a run by itself. After the last input's result it restarts at the lowest selected input, and `busy` stays 1.
- R10: Changes to `seq_mask` or `mux_sel` during a run have no effect until the next start or free-run wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_start | input | 1 | Software start request, one cycle |
| free_run | input | 1 | Continuous conversion mode |
| seq_mask | input | NUM_IN | Inputs to scan; bit i enables input i |
| mux_sel | input | IDX_W | Input used when the mask is empty |
| conv_done | input | 1 | Converter result-done strobe |
| conv_data | input | RES_W | Converter result |
| in_sel | output | IDX_W | Input pair being converted |
| sel_stb | output | 1 | One-cycle pulse at the start of each step |
| busy | output | 1 | Run in progress |
| res_valid | output | 1 | Tagged result valid, one cycle |
| res_data | output | RES_W | Captured result |
| res_tag | output | IDX_W | Input number of the captured result |

## Verification
The bench runs every mask value, and every fixed selection under the empty mask. It alters the mask and the selection during each run. A design that scanned in the wrong order, skipped a bit or repeated one would show a wrong `in_sel`. One that read the live mask would wander off the sampled set. One that ignored the empty-mask fallback would convert nothing or the wrong input.

Starts injected while busy, and done strobes sent while idle, catch a design that restarts or emits phantom results. The free-run case checks that the run wraps with `busy` held high and with the newly sampled mask. It also checks that `busy` falls at once when the mode is dropped.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } seq_st_e;
endpackage

// File: rtl/conv_seq_pick.sv
// Finds the lowest set mask bit, either overall (from_start) or above cur.
module conv_seq_pick #(
  parameter int NUM_IN = 3,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_IN-1:0] mask,
  input  logic [IDX_W-1:0]  cur,
  input  logic              from_start,
  output logic [IDX_W-1:0]  pick,
  output logic              hit
);
  always_comb begin
    pick = '0;
    hit  = 1'b0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (mask[i] && (from_start || i > int'(cur))) begin
        pick = IDX_W'(i);
        hit  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/conv_seq_tag.sv
// Registers a result together with the number of its input.
module conv_seq_tag #(
  parameter int IDX_W = 2,
  parameter int RES_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [RES_W-1:0] data_in,
  input  logic [IDX_W-1:0] tag_in,
  output logic             valid,
  output logic [RES_W-1:0] data,
  output logic [IDX_W-1:0] tag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
      tag   <= '0;
    end else begin
      valid <= take;
      if (take) begin
        data <= data_in;
        tag  <= tag_in;
      end
    end
  end
endmodule

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int NUM_IN = 3,
  parameter int RES_W  = 24,
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_start,
  input  logic              free_run,
  input  logic [NUM_IN-1:0] seq_mask,
  input  logic [IDX_W-1:0]  mux_sel,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic [IDX_W-1:0]  in_sel,
  output logic              sel_stb,
  output logic              busy,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data,
  output logic [IDX_W-1:0]  res_tag
);
  import conv_seq_pkg::*;

  seq_st_e           st;
  logic [NUM_IN-1:0] mask_q;
  logic [IDX_W-1:0]  sel_q;
  logic              stb_q;
  logic [IDX_W-1:0]  first_idx, next_idx, entry_sel;
  logic              first_hit, next_hit;
  logic              trig, accept;

  // Entry point from the live mask (used at start and at free-run wrap).
  conv_seq_pick #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_first (
    .mask(seq_mask), .cur(IDX_W'(0)), .from_start(1'b1),
    .pick(first_idx), .hit(first_hit)
  );

  // Next input above the current one in the sampled mask.
  conv_seq_pick #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_next (
    .mask(mask_q), .cur(sel_q), .from_start(1'b0),
    .pick(next_idx), .hit(next_hit)
  );

  assign trig      = (st == SQ_IDLE) && (sw_start || free_run);
  assign accept    = (st == SQ_RUN) && conv_done;
  assign entry_sel = first_hit ? first_idx : mux_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SQ_IDLE;
      mask_q <= '0;
      sel_q  <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (trig) begin
        st     <= SQ_RUN;
        mask_q <= seq_mask;
        sel_q  <= entry_sel;
        stb_q  <= 1'b1;
      end else if (accept) begin
        if ((|mask_q) && next_hit) begin
          sel_q <= next_idx;
          stb_q <= 1'b1;
        end else if (free_run) begin
          mask_q <= seq_mask;
          sel_q  <= entry_sel;
          stb_q  <= 1'b1;
        end else begin
          st <= SQ_IDLE;
        end
      end
    end
  end

  conv_seq_tag #(.IDX_W(IDX_W), .RES_W(RES_W)) u_tag (
    .clk(clk), .rst(rst), .take(accept), .data_in(conv_data), .tag_in(sel_q),
    .valid(res_valid), .data(res_data), .tag(res_tag)
  );

  assign busy    = (st == SQ_RUN);
  assign in_sel  = sel_q;
  assign sel_stb = stb_q;

  // R2: a run always opens with a step strobe
  a_r2_start_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> sel_stb);

  // R3: within a run that does not wrap, steps only move upward
  a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && sel_stb && !$past(free_run)) |-> (in_sel > $past(in_sel)));

  // R3: with a non-empty sampled mask, the selected input is one of its bits
  a_r3_in_mask: assert property (@(posedge clk) disable iff (rst)
    (busy && (|mask_q)) |-> mask_q[in_sel]);

  // R7: during a run a step strobe comes only from a done strobe
  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    (sel_stb && $past(busy)) |-> $past(conv_done));

  // R5: busy drops only after a done strobe with free-run off
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(conv_done) && !$past(free_run)));

  // R6, R8: a result follows only a done strobe taken while busy
  a_r8_no_idle_result: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($past(busy) && $past(conv_done)));
endmodule

// File: tb/conv_seq_test.sv
module conv_seq_test;
  localparam int NUM_IN = 3;
  localparam int RES_W  = 24;
  localparam int IDX_W  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_start = 1'b0, free_run = 1'b0, conv_done = 1'b0;
  logic [NUM_IN-1:0] seq_mask = '0;
  logic [IDX_W-1:0]  mux_sel = '0;
  logic [RES_W-1:0]  conv_data = '0;
  logic [IDX_W-1:0]  in_sel, res_tag;
  logic              sel_stb, busy, res_valid;
  logic [RES_W-1:0]  res_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  conv_seq #(.NUM_IN(NUM_IN), .RES_W(RES_W)) uut (
    .clk(clk), .rst(rst), .sw_start(sw_start), .free_run(free_run),
    .seq_mask(seq_mask), .mux_sel(mux_sel), .conv_done(conv_done),
    .conv_data(conv_data), .in_sel(in_sel), .sel_stb(sel_stb), .busy(busy),
    .res_valid(res_valid), .res_data(res_data), .res_tag(res_tag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Sends one done strobe and checks the result and the following step.
  task automatic send_done(input logic [RES_W-1:0] d, input int tag,
                           input bit more, input int nxt, input int exp_busy,
                           input string req_next);
    conv_done = 1'b1;
    conv_data = d;
    @(negedge clk);
    conv_done = 1'b0;
    chk(res_valid == 1'b1, "R6 valid", int'(res_valid), 1);
    chk(res_data == d, "R6 data", int'(res_data), int'(d));
    chk(int'(res_tag) == tag, "R6 tag", int'(res_tag), tag);
    chk(int'(busy) == exp_busy, req_next, int'(busy), exp_busy);
    if (more) begin
      chk(sel_stb == 1'b1, req_next, int'(sel_stb), 1);
      chk(int'(in_sel) == nxt, req_next, int'(in_sel), nxt);
    end else begin
      chk(sel_stb == 1'b0, "R5 no strobe", int'(sel_stb), 0);
    end
  endtask

  task automatic run_seq(input logic [NUM_IN-1:0] m, input int mx, input bit poke);
    int lst[NUM_IN];
    int n = 0;
    for (int i = 0; i < NUM_IN; i++) if (m[i]) begin lst[n] = i; n++; end
    if (n == 0) begin lst[0] = mx; n = 1; end
    @(negedge clk);
    seq_mask = m;
    mux_sel  = IDX_W'(mx);
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    seq_mask = ~m;                                  // R10 disturbance
    mux_sel  = IDX_W'((mx + 1) % NUM_IN);
    chk(busy == 1'b1, "R2 busy", int'(busy), 1);
    chk(sel_stb == 1'b1, "R2 strobe", int'(sel_stb), 1);
    chk(int'(in_sel) == lst[0], (m == 0) ? "R4 fallback" : "R2 first",
        int'(in_sel), lst[0]);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(sel_stb == 1'b0, "R3 one-cycle strobe", int'(sel_stb), 0);
      if (poke) sw_start = 1'b1;                    // R7 start while busy
      @(negedge clk);
      sw_start = 1'b0;
      chk(int'(in_sel) == lst[k], "R7 R10 hold", int'(in_sel), lst[k]);
      send_done(RES_W'(int'(m) * 4096 + k * 256 + mx * 16 + 5) | ((k % 2 == 1) ? 24'h800000 : 24'h0),
                lst[k], (k < n - 1), (k < n - 1) ? lst[k + 1] : 0,
                (k < n - 1) ? 1 : 0, (k < n - 1) ? "R3 advance" : "R5 busy clear");
    end
    @(negedge clk);
    chk(res_valid == 1'b0, "R6 single pulse", int'(res_valid), 0);
    chk(busy == 1'b0, "R5 idle", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(sel_stb == 1'b0, "R1 strobe", int'(sel_stb), 0);
    chk(res_valid == 1'b0, "R1 valid", int'(res_valid), 0);
    chk(in_sel == '0, "R1 in_sel", int'(in_sel), 0);
    rst = 1'b0;
    @(negedge clk);

    // R8: done while idle
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    chk(res_valid == 1'b0, "R8 no result", int'(res_valid), 0);
    chk(busy == 1'b0, "R8 no start", int'(busy), 0);

    // Sweep all masks; empty mask with every fixed selection
    for (int m = 1; m < (1 << NUM_IN); m++) begin
      run_seq(NUM_IN'(m), 0, 1'b0);
      run_seq(NUM_IN'(m), m % NUM_IN, 1'b1);
    end
    for (int mx = 0; mx < NUM_IN; mx++) begin
      run_seq('0, mx, 1'b0);
      run_seq('0, mx, 1'b1);
    end

    // R9 free-run
    @(negedge clk);
    seq_mask = 3'b101;
    free_run = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R9 self start", int'(busy), 1);
    chk(int'(in_sel) == 0, "R9 first", int'(in_sel), 0);
    @(negedge clk);
    send_done(24'h00A001, 0, 1'b1, 2, 1, "R9 advance");
    seq_mask = 3'b010;                              // sampled at wrap
    @(negedge clk);
    send_done(24'h00A002, 2, 1'b1, 1, 1, "R9 wrap busy held");
    free_run = 1'b0;
    @(negedge clk);
    send_done(24'h00A003, 1, 1'b0, 0, 0, "R5 free-run off");
    @(negedge clk);
    chk(busy == 1'b0, "R9 stays idle", int'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule